// File: doc/BRIEF.md
# Slow-Clock Edge Coincidence Detector

This block watches two slow clocks that are both timed by one fast clock. One of them is a reference slow clock that arrives from another device. The other is the same frequency, taken from a local output and fed back. The block measures how far apart the rising edges of the two inputs are, in units of half a fast-clock period. It then drives a single status flag. The flag is low while the pair is aligned and high when the pair has drifted apart.

Both slow inputs are sampled on the rising and the falling edge of the fast clock. A rising edge is recognised as a low sample followed by a high sample. When one input rises, a half-period counter starts and waits for the edge of the other input. The edge separation is then compared with a tolerance. Two tolerances are available: a loose one of 2 half-periods, the default, and a tight one of 1 half-period.

The block only reports alignment and does not correct it. Realigning the two clocks is done by an external sync pulse. The inputs are plain control and status pins, and there is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `slowclk_coincidence_det`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `sync_status` is 0.
- R2: When `det_en` is 0, `sync_status` is 0 from the next rising clock edge onward. All pending measurement state is discarded, so a later enable starts a fresh measurement.
- R3: With `win_tight` = 0 and `det_en` = 1, steady slow clocks whose rising edges are at most 2 fast half-periods apart drive `sync_status` to 0. This holds whichever input leads.
- R4: With `win_tight` = 0 and `det_en` = 1, a steady separation of 3 or more half-periods drives `sync_status` to 1.
- R5: With `win_tight` = 1 and `det_en` = 1, a steady separation of at most 1 half-period drives `sync_status` to 0.
- R6: With `win_tight` = 1 and `det_en` = 1, a steady separation of 2 or more half-periods drives `sync_status` to 1.
- R7: If one slow input never rises while the other keeps toggling, `sync_status` goes to 1.
- R8: `sync_status` changes only as the result of a slow-clock rising edge or of `det_en`. Once both slow inputs have stopped changing for 6 cycles and `det_en` has stayed at 1, `sync_status` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock. Both of its edges sample the slow inputs. |
| rst | input | 1 | Synchronous reset, active high. |
| det_en | input | 1 | Detection enable. When it is 0, the status is forced low and all measurement state is cleared. |
| win_tight | input | 1 | Tolerance select: 0 = 2 half-periods, 1 = 1 half-period. |
| slow_ref | input | 1 | Reference slow clock, at most one quarter of the fast clock rate. |
| slow_fb | input | 1 | Local slow clock fed back, at the same frequency as `slow_ref`. |
| sync_status | output | 1 | Coincidence flag: 0 = in sync, 1 = out of sync. |

## Verification
Four properties are checked on every cycle:
- The status is low next to reset.
- The status is low one cycle after the enable drops.
- The status never rises without an earlier slow-clock rising edge.
- The status stays frozen once both slow inputs have been quiet.

The tolerance limits themselves can only be shown by the bench's scenarios. The bench sweeps the signed edge offset in half-period steps across both windows and both enable settings. It holds one input silent, and it freezes both inputs after a decision to show that the status stays put.

// File: rtl/scd_pkg.sv
package scd_pkg;
  // Which input opened the current measurement.
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_REF  = 2'd1,
    PEND_FB   = 2'd2
  } pend_t;

  // Number of half-period slots presented per fast-clock cycle.
  localparam int SLOTS = 2;
endpackage

// File: rtl/scd_half_sampler.sv
// Samples one slow input on both fast-clock edges. On each rising edge it
// presents the two newest samples, and whether a 0->1 change happened in
// the early slot (falling-edge sample) or in the late slot (rising-edge sample).
module scd_half_sampler (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic [scd_pkg::SLOTS-1:0] rise
);
  logic neg_q;
  logic early_q, late_q, prev_late_q;

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b1;
    else     neg_q <= din;
  end

  // Reset to 1 so that an input already high at reset is not seen as an edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      early_q     <= 1'b1;
      late_q      <= 1'b1;
      prev_late_q <= 1'b1;
    end else begin
      early_q     <= neg_q;
      late_q      <= din;
      prev_late_q <= late_q;
    end
  end

  assign rise[0] = early_q & ~prev_late_q;
  assign rise[1] = late_q  & ~early_q;
endmodule

// File: rtl/scd_tracker.sv
// Pairs rising edges of the two inputs and judges their half-period distance.
module scd_tracker #(
  parameter int TOL_LOOSE = 2,
  parameter int TOL_TIGHT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tight,
  input  logic [scd_pkg::SLOTS-1:0] rise_ref,
  input  logic [scd_pkg::SLOTS-1:0] rise_fb,
  output logic flag
);
  import scd_pkg::*;

  localparam int CW = (TOL_LOOSE < 1) ? 1 : $clog2(TOL_LOOSE + 1);

  pend_t         pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    int   tol;
    logic ea, eb, other;
    tol    = tight ? TOL_TIGHT : TOL_LOOSE;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    flag_d = flag_q;
    ea     = 1'b0;
    eb     = 1'b0;
    other  = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      ea = rise_ref[s];
      eb = rise_fb[s];
      if (pend_d != PEND_NONE) begin
        other = (pend_d == PEND_REF) ? eb : ea;
        if (other && (int'(cnt_d) + 1 <= tol)) begin
          // Partner edge inside the window: aligned.
          flag_d = 1'b0;
          pend_d = PEND_NONE;
          ea = 1'b0;
          eb = 1'b0;
        end else if (int'(cnt_d) + 1 > tol) begin
          // Window expired: misaligned, this slot's edges start over.
          flag_d = 1'b1;
          pend_d = PEND_NONE;
        end else begin
          cnt_d = cnt_d + 1'b1;
          ea = 1'b0;
          eb = 1'b0;
        end
      end
      if (pend_d == PEND_NONE) begin
        if (ea && eb) begin
          flag_d = 1'b0;
        end else if (ea) begin
          pend_d = PEND_REF;
          cnt_d  = '0;
        end else if (eb) begin
          pend_d = PEND_FB;
          cnt_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pend_q <= PEND_NONE;
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/slowclk_coincidence_det.sv
module slowclk_coincidence_det #(
  parameter int TOL_LOOSE = 2,
  parameter int TOL_TIGHT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic det_en,
  input  logic win_tight,
  input  logic slow_ref,
  input  logic slow_fb,
  output logic sync_status
);
  import scd_pkg::*;

  localparam int NIN = 2;

  logic [NIN-1:0]   slow_in;
  logic [SLOTS-1:0] rise [NIN];

  assign slow_in = {slow_fb, slow_ref};

  for (genvar i = 0; i < NIN; i++) begin : g_samp
    scd_half_sampler samp_i (
      .clk  (clk),
      .rst  (rst),
      .din  (slow_in[i]),
      .rise (rise[i])
    );
  end

  scd_tracker #(
    .TOL_LOOSE (TOL_LOOSE),
    .TOL_TIGHT (TOL_TIGHT)
  ) trk_i (
    .clk      (clk),
    .rst      (rst),
    .en       (det_en),
    .tight    (win_tight),
    .rise_ref (rise[0]),
    .rise_fb  (rise[1]),
    .flag     (sync_status)
  );
endmodule

// File: rtl/scd_checker.sv
module scd_checker (
  input logic clk,
  input logic rst,
  input logic det_en,
  input logic slow_ref,
  input logic slow_fb,
  input logic sync_status
);
  logic [3:0] since_rst;
  logic [3:0] quiet;
  logic       seen_rise;
  logic       ref_d, fb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      quiet     <= '0;
      seen_rise <= 1'b0;
      ref_d     <= slow_ref;
      fb_d      <= slow_fb;
    end else begin
      ref_d <= slow_ref;
      fb_d  <= slow_fb;
      if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
      if (slow_ref != ref_d || slow_fb != fb_d) quiet <= '0;
      else if (quiet != 4'hF) quiet <= quiet + 4'd1;
      if ((slow_ref && !ref_d) || (slow_fb && !fb_d)) seen_rise <= 1'b1;
    end
  end

  // R1
  a_r1_low_after_reset: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 4'd2) |-> !sync_status);

  // R2
  a_r2_disable_forces_low: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !sync_status);

  // R8
  a_r8_rise_needs_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_status) |-> seen_rise);

  // R8
  a_r8_quiet_holds: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 4'd6 && since_rst >= 4'd2 && det_en && $past(det_en))
      |-> $stable(sync_status));
endmodule

bind slowclk_coincidence_det scd_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .det_en      (det_en),
  .slow_ref    (slow_ref),
  .slow_fb     (slow_fb),
  .sync_status (sync_status)
);

// File: tb/slowclk_coincidence_det_tb_top.sv
`timescale 1ns/1ps
module slowclk_coincidence_det_tb_top;
  localparam int PER = 16;   // slow period in half-periods (8 fast cycles)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic det_en = 1'b0;
  logic win_tight = 1'b0;
  logic slow_ref = 1'b0;
  logic slow_fb = 1'b0;
  logic sync_status;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  int  h = 1000;
  int  d = 0;
  bit  run_ref = 1'b1;
  bit  run_fb = 1'b1;
  bit  freeze = 1'b0;

  slowclk_coincidence_det dut_i (
    .clk(clk), .rst(rst), .det_en(det_en), .win_tight(win_tight),
    .slow_ref(slow_ref), .slow_fb(slow_fb), .sync_status(sync_status)
  );

  always #5 clk = ~clk;

  // Slow clocks advance one half-period step 2.5 ns after each fast edge.
  always @(clk) begin
    #2.5;
    if (!freeze) begin
      h++;
      slow_ref <= run_ref ? ((h % PER) < PER / 2) : 1'b0;
      slow_fb  <= run_fb ? ((((h - d) % PER + PER) % PER) < PER / 2) : 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sync_status=%0b expected=%0b (d=%0d tight=%0b en=%0b)",
               req, act, exp, d, win_tight, det_en);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sweep_point(input int off, input bit tight, input bit en);
    int  tol;
    bit  exp;
    string req;
    tol = tight ? 1 : 2;
    exp = en && ((off < 0 ? -off : off) > tol);
    if (!en) req = "R2";
    else if (!tight) req = exp ? "R4" : "R3";
    else req = exp ? "R6" : "R5";
    @(negedge clk);
    d = off;
    win_tight = tight;
    det_en = en;
    wait_cyc(40);
    for (int k = 0; k < 8; k++) begin
      chk(req, sync_status, exp);
      wait_cyc(1);
    end
  endtask

  initial begin
    wait_cyc(4);
    chk("R1", sync_status, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", sync_status, 1'b0);

    // Offset sweep: R2, R3, R4, R5, R6
    for (int t = 0; t < 2; t++)
      for (int e = 0; e < 2; e++)
        for (int off = -6; off <= 6; off++)
          sweep_point(off, t[0], e[0]);

    // R2: dropping the enable clears a raised flag at the next edge
    sweep_point(5, 1'b0, 1'b1);
    @(negedge clk);
    det_en = 1'b0;
    wait_cyc(1);
    chk("R2", sync_status, 1'b0);
    sweep_point(0, 1'b0, 1'b1);

    // R7: one input silent while the other toggles
    for (int t = 0; t < 2; t++) begin
      @(negedge clk);
      d = 0; run_fb = 1'b0; win_tight = t[0];
      wait_cyc(40);
      chk("R7", sync_status, 1'b1);
      run_fb = 1'b1; run_ref = 1'b0;
      wait_cyc(40);
      chk("R7", sync_status, 1'b1);
      run_ref = 1'b1;
    end

    // R8: frozen inputs leave the status where it was
    sweep_point(4, 1'b0, 1'b1);
    freeze = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wait_cyc(1);
      chk("R8", sync_status, 1'b1);
    end
    freeze = 1'b0;
    sweep_point(1, 1'b0, 1'b1);
    freeze = 1'b1;
    for (int k = 0; k < 20; k++) begin
      wait_cyc(1);
      chk("R8", sync_status, 1'b0);
    end
    freeze = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule